// File: doc/BRIEF.md
# Programmable Interval Countdown Timer

This block is a 16-bit down-counting interval timer for use as a system tick or a one-shot delay source. Its count clock is the system clock divided by two. A control bit can add a further divide-by-64. Software loads an interval into a modulus register and starts the timer with an enable bit. The counter then steps down once per prescaled tick. On the tick that finds it at zero, the timer raises a sticky interrupt flag. In periodic mode the counter then restarts from the modulus. In one-shot mode it wraps to all ones.

A modulus write can be made to reload the counter at once, so a new delay starts without a stop and restart. Software clears the flag by writing a one to the flag bit. This lets a read-modify-write of the control register clear a pending event and leave the other settings unchanged. The live count can be read at any time, and the elapsed ticks are the modulus minus that value.

Top module: `interval_timer`

## Requirements
- R1: After reset the control, modulus and count registers read 0 and `irq_o` is 0.
- R2: While enabled, the counter changes once every 2 clock cycles. When control bit 5 (prescale) is 1, it changes once every 128 clock cycles.
- R3: Writing the control register with bit 0 (enable) going from 0 to 1 loads the counter from the modulus register on that write's clock edge. While enable is 0, the count holds its value and the prescaler phase is cleared.
- R4: A tick that arrives with the counter at 0 is a terminal count, and it sets the flag (control bit 2). In periodic mode, with modulus M and enable written at edge E, terminal counts occur at E + D·(M+1)·k, where D is 2 or 128.
- R5: At terminal count, the counter loads the modulus when control bit 1 (reload) is 1, and wraps to 0xFFFF when it is 0.
- R6: When control bit 4 (overwrite) is 1, a modulus write also loads the counter with the written value on the same edge. When it is 0, a modulus write leaves the running count unchanged.
- R7: A control write with bit 2 set to 1 clears the flag, and with bit 2 set to 0 leaves the flag as it is. Every other control bit takes the written value.
- R8: `irq_o` is a register equal to flag AND control bit 3 (interrupt enable). It changes on the same edge as the bits that drive it.
- R9: Address 0 selects control, 1 selects modulus and 2 selects count. Count is read-only and writes to it are ignored. `rdata_o` is registered and shows the register selected by `addr_i` at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps small modulus values, including zero, in both prescale settings and in periodic mode. It times the first and second terminal counts against D·(M+1). A design off by one in the zero-count handling, or one that restarts the prescaler wrongly, misses those cycles. One-shot runs check the wrap to 0xFFFF, which a design that reloads anyway would fail. Overwrite is placed at an odd cycle offset, so a design that ignores the bit, or loads without it, shows a different expiry cycle. The flag-clear write also checks that the other control bits survive the clear. Interrupt gating is checked by setting the flag with the interrupt disabled and then enabling it.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd0;
  localparam logic [SEL_W-1:0] SEL_MOD  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_CNT  = 2'd2;

  localparam int B_EN   = 0;
  localparam int B_RLD  = 1;
  localparam int B_FLAG = 2;
  localparam int B_IE   = 3;
  localparam int B_OVW  = 4;
  localparam int B_PRE  = 5;
  localparam int CTRL_W = 6;

  typedef struct packed {
    logic pre;
    logic ovw;
    logic ie;
    logic flag;
    logic rld;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
  parameter int BASE_DIV = 2,
  parameter int EXT_DIV  = 64
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  input  logic ext_i,
  output logic tick_o
);
  localparam int FULL = BASE_DIV * EXT_DIV;
  localparam int PW   = $clog2(FULL + 1);

  logic [PW-1:0] ph_q;
  logic [PW-1:0] lim;

  assign lim    = ext_i ? PW'(FULL - 1) : PW'(BASE_DIV - 1);
  assign tick_o = run_i && (ph_q >= lim);

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) ph_q <= '0;
    else if (tick_o)     ph_q <= '0;
    else                 ph_q <= ph_q + 1'b1;
  end

  // R2 (needs BASE_DIV of at least 2)
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> !tick_o);
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         reload_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] cnt_o,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  assign tc_o    = en_i && tick_i && at_zero && !load_i;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)                cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (en_i && tick_i) begin
      if (at_zero)            cnt_q <= reload_i ? mod_i : '1;
      else                    cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5
  oneshot_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (tc_o && !reload_i) |=> (cnt_q == '1));
  // R5
  periodic_reload_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (tc_o && reload_i) |=> (cnt_q == $past(mod_i)));
  // R3
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/itmr_regs.sv
module itmr_regs
  import itmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] addr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             tc_i,
  input  logic [W-1:0]     cnt_i,
  output ctrl_t            ctrl_o,
  output logic [W-1:0]     mod_o,
  output logic             load_o,
  output logic [W-1:0]     load_val_o,
  output logic [W-1:0]     rdata_o,
  output logic             irq_o
);
  ctrl_t        ctrl_q, ctrl_d;
  logic [W-1:0] mod_q, mod_d;
  logic [W-1:0] rdata_q;
  logic         irq_q;
  logic         wr_ctrl, wr_mod;

  assign wr_ctrl = wr_en_i && (addr_i == SEL_CTRL);
  assign wr_mod  = wr_en_i && (addr_i == SEL_MOD);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.en   = wdata_i[B_EN];
      ctrl_d.rld  = wdata_i[B_RLD];
      ctrl_d.ie   = wdata_i[B_IE];
      ctrl_d.ovw  = wdata_i[B_OVW];
      ctrl_d.pre  = wdata_i[B_PRE];
      ctrl_d.flag = ctrl_q.flag && !wdata_i[B_FLAG];
    end
    if (tc_i) ctrl_d.flag = 1'b1;
  end

  assign mod_d      = wr_mod ? wdata_i : mod_q;
  assign load_o     = (wr_ctrl && wdata_i[B_EN] && !ctrl_q.en) || (wr_mod && ctrl_q.ovw);
  assign load_val_o = wr_mod ? wdata_i : mod_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q  <= '0;
      mod_q   <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      mod_q  <= mod_d;
      irq_q  <= ctrl_d.flag && ctrl_d.ie;
      case (addr_i)
        SEL_CTRL: rdata_q <= W'(ctrl_q);
        SEL_MOD:  rdata_q <= mod_q;
        SEL_CNT:  rdata_q <= cnt_i;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign ctrl_o  = ctrl_q;
  assign mod_o   = mod_q;
  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;

  // R4
  flag_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    tc_i |=> ctrl_q.flag);
  // R7
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_ctrl && wdata_i[B_FLAG] && !tc_i) |=> !ctrl_q.flag);
  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_q |-> (ctrl_q.flag && ctrl_q.ie));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int BASE_DIV = 2,
  parameter int EXT_DIV  = 64
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] mod_val, cnt_val, load_val;
  logic             load, tick, tc;

  itmr_regs #(.W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .tc_i       (tc),
    .cnt_i      (cnt_val),
    .ctrl_o     (ctrl),
    .mod_o      (mod_val),
    .load_o     (load),
    .load_val_o (load_val),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o)
  );

  itmr_prescaler #(.BASE_DIV(BASE_DIV), .EXT_DIV(EXT_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .run_i  (ctrl.en),
    .ext_i  (ctrl.pre),
    .tick_o (tick)
  );

  itmr_counter #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .en_i       (ctrl.en),
    .tick_i     (tick),
    .reload_i   (ctrl.rld),
    .load_i     (load),
    .load_val_i (load_val),
    .mod_i      (mod_val),
    .cnt_o      (cnt_val),
    .tc_o       (tc)
  );

  // R3
  enable_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && addr_i == SEL_CTRL && wdata_i[B_EN] && !ctrl.en) |=> (cnt_val == $past(mod_val)));
endmodule

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  localparam int CLK_P = 10;
  localparam logic [15:0] EN = 16'h0001, RLD = 16'h0002, FLG = 16'h0004,
                          IE = 16'h0008, OVW = 16'h0010, PRE = 16'h0020;

  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0, irq;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0, rdata;
  int          cyc = 0, vectors = 0, fails = 0, t_en = 0;
  bit          done = 1'b0;

  interval_timer u_dut (.clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .addr_i(addr),
                        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d (0x%0h), expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    addr = a;
    @(posedge clk); @(negedge clk);
    v = rdata;
  endtask

  task automatic wait_irq(output int dt);
    int n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    dt = cyc - t_en;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic run_periodic(bit pre, int m);
    logic [15:0] v, pb;
    int d1, d2, p;
    pb = pre ? PRE : 16'h0;
    p  = (pre ? 128 : 2) * (m + 1);
    wr(2'd0, FLG);
    wr(2'd1, 16'(m));
    wr(2'd0, EN | RLD | IE | pb);
    t_en = cyc;
    wait_irq(d1);
    check("R4 first expiry (R2 rate)", d1, p);
    wr(2'd0, EN | RLD | IE | pb | FLG);
    rd(2'd0, v);
    check("R7 flag clear keeps other bits", int'(v), int'(EN | RLD | IE | pb));
    wait_irq(d2);
    check("R4 second expiry", d2, 2 * p);
    wr(2'd0, 16'h0);
    rd(2'd2, v);
    check("R5 periodic reload value", int'(v), m);
  endtask

  task automatic run_oneshot(int m);
    logic [15:0] v;
    int d1;
    wr(2'd0, FLG);
    wr(2'd1, 16'(m));
    wr(2'd0, EN | IE);
    t_en = cyc;
    wait_irq(d1);
    check("R4 one-shot expiry", d1, 2 * (m + 1));
    wr(2'd0, 16'h0);
    rd(2'd2, v);
    check("R5 one-shot wrap", int'(v), 16'hFFFF);
  endtask

  initial begin
    #(CLK_P * 195000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v, v2;
    int d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", int'(irq), 0);
    rd(2'd0, v); check("R1 ctrl", int'(v), 0);
    rd(2'd1, v); check("R1 modulus", int'(v), 0);
    rd(2'd2, v); check("R1 count", int'(v), 0);

    for (int m = 0; m < 16; m++) run_periodic(1'b0, m);
    for (int m = 0; m < 3; m++)  run_periodic(1'b1, m);
    for (int m = 0; m < 8; m++)  run_oneshot(m);

    // R3 enable loads, R2 prescale rate, hold while disabled
    wr(2'd0, FLG);
    wr(2'd1, 16'h1234);
    wr(2'd0, EN | PRE);
    rd(2'd2, v);
    check("R3 enable loads modulus", int'(v), 16'h1234);
    repeat (130) @(negedge clk);
    rd(2'd2, v);
    check("R2 one tick after 128 cycles (elapsed)", 16'h1234 - int'(v), 1);
    wr(2'd0, PRE);
    rd(2'd2, v);
    repeat (300) @(negedge clk);
    rd(2'd2, v2);
    check("R3 count holds while disabled", int'(v2), int'(v));
    // R9 count is read-only
    wr(2'd2, 16'h0042);
    rd(2'd2, v2);
    check("R9 count write ignored", int'(v2), int'(v));
    rd(2'd1, v2);
    check("R9 modulus readback", int'(v2), 16'h1234);
    wr(2'd0, EN | PRE);
    rd(2'd2, v);
    check("R3 re-enable reloads", int'(v), 16'h1234);

    // R6 overwrite on: new delay starts at write edge E+5
    wr(2'd0, FLG);
    wr(2'd1, 16'd50);
    wr(2'd0, EN | IE | OVW);
    t_en = cyc;
    repeat (4) @(negedge clk);
    wr(2'd1, 16'd3);
    wait_irq(d);
    check("R6 overwrite restarts delay", d, 12);
    // R6 overwrite off: running count unaffected
    wr(2'd0, FLG);
    wr(2'd1, 16'd10);
    wr(2'd0, EN | IE);
    t_en = cyc;
    repeat (4) @(negedge clk);
    wr(2'd1, 16'd3);
    wait_irq(d);
    check("R6 no overwrite keeps delay", d, 22);

    // R8 interrupt gating
    wr(2'd0, FLG);
    wr(2'd1, 16'd2);
    wr(2'd0, EN | RLD);
    repeat (20) @(negedge clk);
    check("R8 irq masked", int'(irq), 0);
    rd(2'd0, v);
    check("R8 flag set while masked", int'(v & FLG), int'(FLG));
    wr(2'd0, EN | RLD | IE);
    check("R8 irq after enable", int'(irq), 1);
    wr(2'd0, FLG);
    check("R8 irq drops on clear", int'(irq), 0);
    rd(2'd0, v);
    check("R7 clear write leaves flag 0", int'(v), 0);

    finish_run();
  end
endmodule